// File: doc/BRIEF.md
# Spur-Cancelling Auxiliary Tone Combiner

This block holds two numerically controlled oscillators that run from one clock and whose scaled cosine samples are added into a single output word for a DAC. The main channel makes the wanted tone. The auxiliary channel has its own tuning word, phase offset and gain. Software points the auxiliary tone at the frequency of a known spur, gives it the same amplitude as the spur and places it half a turn away in phase, so that the spur cancels in the digital sum before conversion.

Register writes go into shadow copies. A single commit strobe moves the shadow settings of both channels into the working registers on the same edge, so retuning never leaves the two tones in a mixed state. When both channels have the same tuning word, their phase relation is fixed by their offsets. The combined sample saturates at the output width and does not wrap. A disable bit for the auxiliary channel removes its contribution completely.

Top module: `spur_cancel_combiner`

## Requirements
- R1: A synchronous active-high reset clears every tuning word, offset and gain to zero, disables the auxiliary channel and drives `sample_out` to 0 on the edge that samples reset. With no further writes the output stays 0.
- R2: A write with `wr_en` high stores `wr_data` into the shadow field picked by `wr_chan` (0 main, 1 auxiliary) and `wr_field` (0 tuning word, 1 phase offset, 2 gain in the low 12 bits, 3 enable in bit 0). Shadow values have no effect at the output until `commit` is high, and that edge copies the shadows of both channels into the working registers together.
- R3: On every clock each accumulator adds its working tuning word modulo 2^24. The phase index given to the converter is bits 23..16 of (accumulator + phase offset) modulo 2^24. The lower bits are truncated.
- R4: The converter maps index i (0..255) to a sign and a magnitude. Let f = i for i < 128 and f = 256 - i otherwise. If f <= 64, then m = f and the sign is positive. Otherwise m = 128 - f and the sign is negative. The magnitude is 2047 - floor(2047*m*m/4096).
- R5: A channel's contribution is floor(magnitude*gain/4096), negated when the sign is negative. Indices half a turn apart therefore give contributions that are exact negatives of each other.
- R6: The output is the sum of both contributions, clamped to the 12-bit signed range [-2048, 2047] instead of wrapping.
- R7: When the auxiliary enable bit is 0, the auxiliary contribution is 0. The main channel is always enabled, and enable writes to it have no effect.
- R8: If both channels share a tuning word and gain, and the auxiliary offset exceeds the main offset by 2^23, the output is 0 on every cycle.
- R9: Latency: after a commit at edge e, the output sampled after edge e+1 still reflects the old settings. The output after edge e+2+k reflects the accumulator value that stood after edge e+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both channels |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Shadow register write strobe |
| wr_chan | input | 1 | Channel select: 0 main, 1 auxiliary |
| wr_field | input | 2 | Field select: tuning, offset, gain, enable |
| wr_data | input | 24 | Write data |
| commit | input | 1 | Copies both channels' shadows into working registers |
| sample_out | output | 12 | Saturated signed combined sample |

## Verification
A corrupted working register or accumulator shows up at `sample_out` two cycles later. A wrong accumulator step shows as a drift of the phase index that grows every cycle, so a sweep over a few dozen cycles exposes it. A wrong sign or fold in the converter breaks the exact zero of the anti-phase pair, and a shadow leak changes the output before the commit strobe. A wrapping adder gives a value of the wrong sign instead of the rail, which shows on the first cycle that two full-scale tones line up.

// File: rtl/spur_pkg.sv
package spur_pkg;

    localparam int NCH      = 2;
    localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int CH_MAIN  = 0;
    localparam int CH_AUX   = 1;
    localparam int PHASE_W  = 24;
    localparam int IDX_W    = 8;
    localparam int SAMP_W   = 12;
    localparam int MAG_W    = SAMP_W - 1;
    localparam int GAIN_W   = 12;
    localparam int OUT_W    = 12;
    localparam int SUM_W    = SAMP_W + CH_W;
    localparam int FIELD_W  = 2;
    localparam int SQ_W     = MAG_W + 2 * IDX_W;
    localparam int SQ_SHIFT = 2 * (IDX_W - 2);

    localparam logic [IDX_W-1:0] QTR_IDX  = IDX_W'(1 << (IDX_W - 2));
    localparam logic [IDX_W-1:0] HALF_IDX = IDX_W'(1 << (IDX_W - 1));
    localparam logic [MAG_W-1:0] AMP_MAX  = '1;

    localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] SAT_LO = SUM_W'(-(2 ** (OUT_W - 1)));

    typedef enum logic [FIELD_W-1:0] {
        FLD_TUNE   = 2'd0,
        FLD_OFFSET = 2'd1,
        FLD_GAIN   = 2'd2,
        FLD_ENABLE = 2'd3
    } field_e;

    typedef struct packed {
        logic [PHASE_W-1:0] tune;
        logic [PHASE_W-1:0] offset;
        logic [GAIN_W-1:0]  gain;
        logic               enable;
    } chan_cfg_t;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } wave_t;

    // Folded parabolic cosine: sign and magnitude, symmetric under a half turn.
    function automatic wave_t cos_approx(input logic [IDX_W-1:0] idx);
        logic [IDX_W-1:0] fold;
        logic [IDX_W-1:0] m;
        logic [SQ_W-1:0]  sq;
        wave_t            w;
        fold = idx[IDX_W-1] ? (~idx + 1'b1) : idx;
        if (fold <= QTR_IDX) begin
            m     = fold;
            w.neg = 1'b0;
        end else begin
            m     = HALF_IDX - fold;
            w.neg = 1'b1;
        end
        sq    = SQ_W'(AMP_MAX) * SQ_W'(m) * SQ_W'(m);
        w.mag = AMP_MAX - MAG_W'(sq >> SQ_SHIFT);
        return w;
    endfunction

    function automatic logic signed [OUT_W-1:0] saturate(input logic signed [SUM_W-1:0] s);
        if (s > SAT_HI)
            return {1'b0, {(OUT_W-1){1'b1}}};
        else if (s < SAT_LO)
            return {1'b1, {(OUT_W-1){1'b0}}};
        else
            return s[OUT_W-1:0];
    endfunction

endpackage

// File: rtl/spur_cfg_regs.sv
module spur_cfg_regs
    import spur_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [CH_W-1:0]    wr_chan,
    input  logic [FIELD_W-1:0] wr_field,
    input  logic [PHASE_W-1:0] wr_data,
    input  logic               commit,
    output chan_cfg_t          act_cfg [NCH]
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic HAS_EN = (c != CH_MAIN);
        localparam chan_cfg_t RST_CFG = '{tune: '0, offset: '0, gain: '0, enable: !HAS_EN};

        chan_cfg_t shadow_q;
        chan_cfg_t active_q;
        logic      sel;

        assign sel = wr_en && (wr_chan == CH_W'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q <= RST_CFG;
                active_q <= RST_CFG;
            end else begin
                if (sel) begin
                    case (field_e'(wr_field))
                        FLD_TUNE:   shadow_q.tune   <= wr_data;
                        FLD_OFFSET: shadow_q.offset <= wr_data;
                        FLD_GAIN:   shadow_q.gain   <= wr_data[GAIN_W-1:0];
                        FLD_ENABLE: if (HAS_EN) shadow_q.enable <= wr_data[0];
                        default:    ;
                    endcase
                end
                if (commit)
                    active_q <= shadow_q;
            end
        end

        assign act_cfg[c] = active_q;
    end

endmodule

// File: rtl/spur_phase_acc.sv
module spur_phase_acc
    import spur_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] tune,
    input  logic [PHASE_W-1:0] offset,
    output logic [PHASE_W-1:0] acc,
    output logic [IDX_W-1:0]   idx
);

    logic [PHASE_W-1:0]       acc_q;
    logic [PHASE_W-IDX_W-1:0] frac_unused;

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else
            acc_q <= acc_q + tune;
    end

    assign {idx, frac_unused} = acc_q + offset;
    assign acc = acc_q;

endmodule

// File: rtl/spur_tone_shaper.sv
module spur_tone_shaper
    import spur_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [IDX_W-1:0]         idx,
    input  logic [GAIN_W-1:0]        gain,
    input  logic                     enable,
    output logic signed [SAMP_W-1:0] scaled
);

    localparam int PROD_W = MAG_W + GAIN_W;

    wave_t                     w;
    logic [PROD_W-1:0]         prod;
    logic [MAG_W-1:0]          lvl;
    logic signed [SAMP_W-1:0]  lvl_s;

    assign w     = cos_approx(idx);
    assign prod  = PROD_W'(w.mag) * PROD_W'(gain);
    assign lvl   = MAG_W'(prod >> GAIN_W);
    assign lvl_s = w.neg ? -$signed({1'b0, lvl}) : $signed({1'b0, lvl});

    always_ff @(posedge clk) begin
        if (rst)
            scaled <= '0;
        else
            scaled <= enable ? lvl_s : '0;
    end

endmodule

// File: rtl/spur_sum_sat.sv
module spur_sum_sat
    import spur_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [SAMP_W-1:0] parts [NCH],
    output logic signed [OUT_W-1:0]  sample
);

    logic signed [SUM_W-1:0] total;

    always_comb begin
        total = '0;
        for (int c = 0; c < NCH; c++)
            total = total + SUM_W'(parts[c]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            sample <= '0;
        else
            sample <= saturate(total);
    end

endmodule

// File: rtl/spur_cancel_combiner.sv
module spur_cancel_combiner
    import spur_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [CH_W-1:0]         wr_chan,
    input  logic [FIELD_W-1:0]      wr_field,
    input  logic [PHASE_W-1:0]      wr_data,
    input  logic                    commit,
    output logic signed [OUT_W-1:0] sample_out
);

    chan_cfg_t                act_cfg [NCH];
    logic [PHASE_W-1:0]       acc     [NCH];
    logic [IDX_W-1:0]         idx     [NCH];
    logic signed [SAMP_W-1:0] scaled  [NCH];

    spur_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_chan  (wr_chan),
        .wr_field (wr_field),
        .wr_data  (wr_data),
        .commit   (commit),
        .act_cfg  (act_cfg)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        spur_phase_acc u_acc (
            .clk    (clk),
            .rst    (rst),
            .tune   (act_cfg[c].tune),
            .offset (act_cfg[c].offset),
            .acc    (acc[c]),
            .idx    (idx[c])
        );

        spur_tone_shaper u_shape (
            .clk    (clk),
            .rst    (rst),
            .idx    (idx[c]),
            .gain   (act_cfg[c].gain),
            .enable (act_cfg[c].enable),
            .scaled (scaled[c])
        );
    end

    spur_sum_sat u_sum (
        .clk    (clk),
        .rst    (rst),
        .parts  (scaled),
        .sample (sample_out)
    );

endmodule

// File: rtl/spur_cancel_checker.sv
module spur_cancel_checker
    import spur_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     commit,
    input chan_cfg_t                main_cfg,
    input chan_cfg_t                aux_cfg,
    input logic [PHASE_W-1:0]       main_acc,
    input logic signed [SAMP_W-1:0] scaled_main,
    input logic signed [SAMP_W-1:0] scaled_aux,
    input logic signed [OUT_W-1:0]  sample_out
);

    localparam logic signed [SAMP_W:0] TOP = (SAMP_W+1)'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [SAMP_W:0] BOT = (SAMP_W+1)'(-(2 ** (OUT_W - 1)));

    logic signed [SAMP_W:0] pair_sum;
    logic signed [SAMP_W:0] out_ext;
    logic                   rst_q;

    assign pair_sum = (SAMP_W+1)'(scaled_main) + (SAMP_W+1)'(scaled_aux);
    assign out_ext  = (SAMP_W+1)'(sample_out);

    always_ff @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q) begin
            assert_reset_clear_R1: assert (sample_out == '0)
                else $error("output not cleared after reset");
        end
    end

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(main_cfg) && $stable(aux_cfg)));

    assert_acc_step_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (main_acc == $past(main_acc) + $past(main_cfg.tune)));

    assert_aux_off_R7: assert property (@(posedge clk) disable iff (rst)
        !aux_cfg.enable |=> (scaled_aux == '0));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (pair_sum > TOP) |=> (out_ext == TOP));

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        (pair_sum < BOT) |=> (out_ext == BOT));

    assert_pass_sum_R9: assert property (@(posedge clk) disable iff (rst)
        (pair_sum <= TOP && pair_sum >= BOT) |=> (out_ext == $past(pair_sum)));

endmodule

bind spur_cancel_combiner spur_cancel_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .commit      (commit),
    .main_cfg    (act_cfg[CH_MAIN]),
    .aux_cfg     (act_cfg[CH_AUX]),
    .main_acc    (acc[CH_MAIN]),
    .scaled_main (scaled[CH_MAIN]),
    .scaled_aux  (scaled[CH_AUX]),
    .sample_out  (sample_out)
);

// File: tb/tb_spur_cancel_combiner.sv
`timescale 1ns/1ps
module tb_spur_cancel_combiner;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               wr_en = 1'b0;
    logic [0:0]         wr_chan = '0;
    logic [1:0]         wr_field = '0;
    logic [23:0]        wr_data = '0;
    logic               commit = 1'b0;
    logic signed [11:0] sample_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    spur_cancel_combiner dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_chan    (wr_chan),
        .wr_field   (wr_field),
        .wr_data    (wr_data),
        .commit     (commit),
        .sample_out (sample_out)
    );

    typedef struct packed {
        int mi; int mg; int ai; int ag; int aen;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{0,   4095, 0,   0,    0},
        '{0,   4095, 128, 4095, 1},
        '{0,   4095, 0,   4095, 1},
        '{128, 4095, 128, 4095, 1},
        '{32,  2048, 160, 2048, 1},
        '{32,  4095, 0,   1024, 0},
        '{200, 3000, 10,  1500, 1},
        '{64,  4095, 100, 2000, 1}
    };

    localparam int TUNE_A = 32'h0D8000;

    // Converter and scaling as defined by R4 and R5.
    function automatic int ref_part(int idx, int gain);
        int fold, m, mag, p;
        bit neg;
        idx  = idx % 256;
        fold = (idx >= 128) ? 256 - idx : idx;
        if (fold <= 64) begin m = fold; neg = 0; end
        else begin m = 128 - fold; neg = 1; end
        mag = 2047 - (2047 * m * m) / 4096;
        p   = (mag * gain) / 4096;
        return neg ? -p : p;
    endfunction

    function automatic int clamp12(int s);
        if (s > 2047) return 2047;
        if (s < -2048) return -2048;
        return s;
    endfunction

    task automatic check(int exp, string req);
        int act;
        act = int'(sample_out);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int ch, int fld, int data);
        @(negedge clk);
        wr_en    = 1'b1;
        wr_chan  = 1'(ch);
        wr_field = 2'(fld);
        wr_data  = 24'(data);
        @(negedge clk);
        wr_en    = 1'b0;
    endtask

    task automatic do_commit();
        @(negedge clk);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        int exp_v;
        int hold_v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(posedge clk);
        #1 check(0, "R1 reset output");

        // Vector table: static phases (tuning word 0), accumulators stay at 0.
        for (int v = 0; v < 8; v++) begin
            wr(0, 0, 0);
            wr(0, 1, VECS[v].mi << 16);
            wr(0, 2, VECS[v].mg);
            wr(1, 0, 0);
            wr(1, 1, VECS[v].ai << 16);
            wr(1, 2, VECS[v].ag);
            wr(1, 3, VECS[v].aen);
            do_commit();
            repeat (3) @(posedge clk);
            exp_v = clamp12(ref_part(VECS[v].mi, VECS[v].mg) +
                            (VECS[v].aen != 0 ? ref_part(VECS[v].ai, VECS[v].ag) : 0));
            #1 check(exp_v, "R4 R5 R6 R7 table");
        end

        // Shadow isolation and commit latency.
        wr(0, 1, 0);
        wr(0, 2, 4095);
        wr(1, 3, 0);
        do_commit();
        repeat (3) @(posedge clk);
        hold_v = ref_part(0, 4095);
        #1 check(hold_v, "R7 aux disabled");
        wr(0, 2, 1000);
        repeat (5) @(posedge clk);
        #1 check(hold_v, "R2 shadow not visible before commit");
        do_commit();
        @(posedge clk);
        #1 check(hold_v, "R9 old value one cycle after commit");
        @(posedge clk);
        #1 check(ref_part(0, 1000), "R9 new value two cycles after commit");
        wr(0, 3, 0);
        do_commit();
        repeat (4) @(posedge clk);
        #1 check(ref_part(0, 1000), "R7 main enable write ignored");

        // Reset from a nonzero output.
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1 check(0, "R1 reset clears output");
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(posedge clk);
        #1 check(0, "R1 registers cleared, output stays zero");

        // Running sweep with truncated fractional tuning word.
        wr(0, 0, TUNE_A);
        wr(0, 2, 4095);
        do_commit();
        @(posedge clk);
        #1 check(0, "R9 sweep first cycle keeps old output");
        for (int k = 0; k < 40; k++) begin
            @(posedge clk);
            exp_v = clamp12(ref_part(((k * TUNE_A) % (1 << 24)) >> 16, 4095));
            #1 check(exp_v, "R3 R4 sweep");
        end

        // Anti-phase cancellation while both channels run.
        do_reset();
        wr(0, 0, TUNE_A);
        wr(0, 1, 5 << 16);
        wr(0, 2, 4095);
        wr(1, 0, TUNE_A);
        wr(1, 1, 133 << 16);
        wr(1, 2, 4095);
        wr(1, 3, 1);
        do_commit();
        for (int k = 0; k < 30; k++) begin
            @(posedge clk);
            #1 check(0, "R8 running cancellation");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule